// File: doc/BRIEF.md
# DDR2 SDRAM Power-Up Initialization Sequencer

This block brings a DDR2 SDRAM from power-up to its operating mode. After a synchronous reset it holds the clock-enable pin low for a long settling interval and drives only NOP on the command pins. It then raises clock-enable, waits a short interval and issues a fixed chain of commands. The chain precharges all banks, loads the four mode registers, resets the DLL, refreshes, programs the operating mode and steps the output driver calibration into its default setting and back out. Every gap between commands is a parameter counted in clock cycles. At full scale the long wait is tens of thousands of cycles; a test build shortens it.

The mode-register contents arrive on four configuration inputs. The sequencer forces the bits that the sequence itself owns: DLL enable, DLL reset and the three driver-calibration bits. When the last gap has elapsed it raises `init_done` so a normal-operation controller can take over the pins. A second flag, `read_ok`, goes high only when the DLL lock interval since the DLL-reset command has also elapsed.

Top module: `ddr2_boot_seq`

## Requirements
- R1: While `rst` is high, and for the first T_CKE_LOW rising edges after it falls, `cke` is low and the command on {cs_n,ras_n,cas_n,we_n} is NOP = 0111, with `ba` and `addr` zero. `cke` becomes high at rising edge T_CKE_LOW, counting the first edge with `rst` low as edge 1.
- R2: Once high, `cke` stays high until the next reset.
- R3: The first command other than NOP appears exactly T_SETTLE edges after `cke` rises. It is PRECHARGE (0010) with addr bit 10 set, every other addr bit zero and `ba` zero.
- R4: The commands come in this order: PRECHARGE all, LOAD MODE (0000) to `ba`=10, LOAD MODE to `ba`=11, LOAD MODE to `ba`=01 (DLL enable), LOAD MODE to `ba`=00 (DLL reset), PRECHARGE all, NUM_REF times REFRESH (0001), LOAD MODE to `ba`=00 (operating), LOAD MODE to `ba`=01 (calibration default), LOAD MODE to `ba`=01 (calibration exit).
- R5: The distance from each command to the next is exactly T_RPA after a PRECHARGE, T_RFC after a REFRESH and T_MRD after a LOAD MODE. Every cycle in between carries NOP with `ba` and `addr` zero.
- R6: The `ba`=10 and `ba`=11 loads carry `emr2_cfg` and `emr3_cfg` unchanged.
- R7: The DLL-enable load carries `emr_cfg` with bit 0 cleared and bits 9:7 cleared.
- R8: The DLL-reset load carries `mr_cfg` with bit 8 set. The operating load carries `mr_cfg` with bit 8 cleared.
- R9: The calibration-default load carries `emr_cfg` with bits 9:7 = 111 and bit 0 cleared. The calibration-exit load carries `emr_cfg` with bits 9:7 = 000 and bit 0 cleared.
- R10: Each REFRESH drives `ba` and `addr` zero.
- R11: `init_done` rises exactly T_MRD edges after the calibration-exit load and stays high until reset. No command other than NOP follows.
- R12: `read_ok` is high only while `init_done` is high and at least T_DLL edges have passed since the DLL-reset load.
- R13: A reset during the sequence restarts it from the clock-enable-low state, and the full sequence then repeats with the same timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst | input | 1 | Synchronous active-high reset; restarts the sequence |
| mr_cfg | input | ADDR_W | Operating value of the mode register |
| emr_cfg | input | ADDR_W | Operating value of extended mode register 1 |
| emr2_cfg | input | ADDR_W | Value for extended mode register 2 |
| emr3_cfg | input | ADDR_W | Value for extended mode register 3 |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address / mode-register select |
| addr | output | ADDR_W | Address bus / mode-register payload |
| init_done | output | 1 | Sequence complete; pins may be handed over |
| read_ok | output | 1 | DLL lock interval elapsed and sequence complete |

## Verification
A wrong step index shows on the very next command edge. The command code, bank select or payload is then wrong, or the command arrives in the wrong slot of the chain, so a check of each command against its expected cycle catches it at once. A wrong gap count moves every later command, so the error shows as a cycle offset at the next command and does not wait for the end. A fault in the DLL lock counter shows only on `read_ok`: at default scale the rise moves by up to T_DLL cycles after `init_done`, so that flag is compared on every cycle.

// File: rtl/ddr2_boot_pkg.sv
package ddr2_boot_pkg;

    // Command codes on {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_LMR = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_NOP = 4'b0111
    } cmd_e;

    // Mode register selected by the bank address
    typedef enum logic [1:0] {
        MSEL_MR   = 2'd0,
        MSEL_EMR1 = 2'd1,
        MSEL_EMR2 = 2'd2,
        MSEL_EMR3 = 2'd3
    } msel_e;

    typedef enum logic [2:0] {
        PH_CKE_LOW,
        PH_SETTLE,
        PH_CMD,
        PH_GAP,
        PH_DONE
    } phase_e;

    typedef enum logic [3:0] {
        SK_PRE_A,
        SK_EMR2,
        SK_EMR3,
        SK_EMR_DLL,
        SK_MR_RST,
        SK_PRE_B,
        SK_REF,
        SK_MR_OP,
        SK_EMR_OCD,
        SK_EMR_EXIT
    } step_kind_e;

    typedef struct packed {
        cmd_e  cmd;
        msel_e sel;
    } cmd_word_t;

    // Steps that are always present; refreshes are added on top
    localparam int FIXED_STEPS = 9;
    localparam int HEAD_STEPS  = 6;

    // Mode-register bit positions the sequence itself owns
    localparam int BIT_PRE_ALL = 10;
    localparam int BIT_DLL_RST = 8;
    localparam int BIT_DLL_DIS = 0;
    localparam int BIT_OCD_LO  = 7;
    localparam int BIT_OCD_HI  = 9;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic step_kind_e step_kind(input int idx, input int nref);
        step_kind_e k;
        if (idx < HEAD_STEPS) begin
            case (idx)
                0:       k = SK_PRE_A;
                1:       k = SK_EMR2;
                2:       k = SK_EMR3;
                3:       k = SK_EMR_DLL;
                4:       k = SK_MR_RST;
                default: k = SK_PRE_B;
            endcase
        end else if (idx < HEAD_STEPS + nref) begin
            k = SK_REF;
        end else begin
            case (idx - HEAD_STEPS - nref)
                0:       k = SK_MR_OP;
                1:       k = SK_EMR_OCD;
                default: k = SK_EMR_EXIT;
            endcase
        end
        return k;
    endfunction

    function automatic int gap_cycles(input step_kind_e k, input int rpa,
                                      input int rfc, input int mrd);
        int g;
        case (k)
            SK_PRE_A, SK_PRE_B: g = rpa;
            SK_REF:             g = rfc;
            default:            g = mrd;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/ddr2_boot_timer.sv
module ddr2_boot_timer #(
    parameter int CW      = 16,
    parameter int RST_VAL = 0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= CW'(RST_VAL);
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/ddr2_boot_dll_lock.sv
module ddr2_boot_dll_lock #(
    parameter int T_DLL = 200,
    localparam int CW   = $clog2(T_DLL + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic locked
);

    logic [CW-1:0] cnt_q;
    logic          armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            cnt_q   <= '0;
        end else if (start) begin
            armed_q <= 1'b1;
            cnt_q   <= CW'(T_DLL - 1);
        end else if (armed_q && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign locked = armed_q && (cnt_q == '0);

endmodule

// File: rtl/ddr2_boot_cmdgen.sv
module ddr2_boot_cmdgen
    import ddr2_boot_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  logic              active,
    input  step_kind_e        kind,
    input  logic [ADDR_W-1:0] mr_cfg,
    input  logic [ADDR_W-1:0] emr_cfg,
    input  logic [ADDR_W-1:0] emr2_cfg,
    input  logic [ADDR_W-1:0] emr3_cfg,
    output cmd_word_t         word,
    output logic [ADDR_W-1:0] addr
);

    always_comb begin
        word.cmd = CMD_NOP;
        word.sel = MSEL_MR;
        addr     = '0;
        if (active) begin
            case (kind)
                SK_PRE_A, SK_PRE_B: begin
                    word.cmd          = CMD_PRE;
                    addr[BIT_PRE_ALL] = 1'b1;
                end
                SK_EMR2: begin
                    word.cmd = CMD_LMR;
                    word.sel = MSEL_EMR2;
                    addr     = emr2_cfg;
                end
                SK_EMR3: begin
                    word.cmd = CMD_LMR;
                    word.sel = MSEL_EMR3;
                    addr     = emr3_cfg;
                end
                SK_EMR_DLL, SK_EMR_EXIT: begin
                    word.cmd                      = CMD_LMR;
                    word.sel                      = MSEL_EMR1;
                    addr                          = emr_cfg;
                    addr[BIT_DLL_DIS]             = 1'b0;
                    addr[BIT_OCD_HI:BIT_OCD_LO]   = 3'b000;
                end
                SK_EMR_OCD: begin
                    word.cmd                      = CMD_LMR;
                    word.sel                      = MSEL_EMR1;
                    addr                          = emr_cfg;
                    addr[BIT_DLL_DIS]             = 1'b0;
                    addr[BIT_OCD_HI:BIT_OCD_LO]   = 3'b111;
                end
                SK_MR_RST: begin
                    word.cmd          = CMD_LMR;
                    word.sel          = MSEL_MR;
                    addr              = mr_cfg;
                    addr[BIT_DLL_RST] = 1'b1;
                end
                SK_MR_OP: begin
                    word.cmd          = CMD_LMR;
                    word.sel          = MSEL_MR;
                    addr              = mr_cfg;
                    addr[BIT_DLL_RST] = 1'b0;
                end
                SK_REF: begin
                    word.cmd = CMD_REF;
                end
                default: begin
                    word.cmd = CMD_NOP;
                end
            endcase
        end
    end

endmodule

// File: rtl/ddr2_boot_seq.sv
module ddr2_boot_seq
    import ddr2_boot_pkg::*;
#(
    parameter int ADDR_W    = 14,
    parameter int BA_W      = 2,
    parameter int T_CKE_LOW = 40000,
    parameter int T_SETTLE  = 80,
    parameter int T_RPA     = 4,
    parameter int T_MRD     = 2,
    parameter int T_RFC     = 26,
    parameter int T_DLL     = 200,
    parameter int NUM_REF   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] mr_cfg,
    input  logic [ADDR_W-1:0] emr_cfg,
    input  logic [ADDR_W-1:0] emr2_cfg,
    input  logic [ADDR_W-1:0] emr3_cfg,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr,
    output logic              init_done,
    output logic              read_ok
);

    localparam int NSTEP = FIXED_STEPS + NUM_REF;
    localparam int SW    = $clog2(NSTEP + 1);
    localparam int MAXT  = max2(max2(T_CKE_LOW, T_SETTLE),
                                max2(max2(T_RPA, T_MRD), T_RFC));
    localparam int CW    = $clog2(MAXT + 1);

    phase_e        phase_q, phase_d;
    logic [SW-1:0] step_q, step_d;
    step_kind_e    kind;
    int            gap;
    logic          last_step;
    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_expired;
    logic          dll_start;
    logic          dll_locked;
    cmd_word_t     word;

    assign kind      = step_kind(int'(step_q), NUM_REF);
    assign gap       = gap_cycles(kind, T_RPA, T_RFC, T_MRD);
    assign last_step = (step_q == SW'(NSTEP - 1));

    ddr2_boot_timer #(
        .CW      (CW),
        .RST_VAL (T_CKE_LOW - 1)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    always_comb begin
        phase_d  = phase_q;
        step_d   = step_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (phase_q)
            PH_CKE_LOW: begin
                if (tmr_expired) begin
                    phase_d  = PH_SETTLE;
                    tmr_load = 1'b1;
                    tmr_val  = CW'(T_SETTLE - 1);
                end
            end
            PH_SETTLE: begin
                if (tmr_expired) begin
                    phase_d = PH_CMD;
                    step_d  = '0;
                end
            end
            PH_CMD: begin
                if (gap > 1) begin
                    phase_d  = PH_GAP;
                    tmr_load = 1'b1;
                    tmr_val  = CW'(gap - 2);
                end else if (last_step) begin
                    phase_d = PH_DONE;
                end else begin
                    step_d = step_q + 1'b1;
                end
            end
            PH_GAP: begin
                if (tmr_expired) begin
                    if (last_step) begin
                        phase_d = PH_DONE;
                    end else begin
                        phase_d = PH_CMD;
                        step_d  = step_q + 1'b1;
                    end
                end
            end
            default: begin
                phase_d = PH_DONE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_CKE_LOW;
            step_q  <= '0;
        end else begin
            phase_q <= phase_d;
            step_q  <= step_d;
        end
    end

    assign dll_start = (phase_q == PH_CMD) && (kind == SK_MR_RST);

    ddr2_boot_dll_lock #(
        .T_DLL (T_DLL)
    ) u_dll (
        .clk    (clk),
        .rst    (rst),
        .start  (dll_start),
        .locked (dll_locked)
    );

    ddr2_boot_cmdgen #(
        .ADDR_W (ADDR_W)
    ) u_cmdgen (
        .active   (phase_q == PH_CMD),
        .kind     (kind),
        .mr_cfg   (mr_cfg),
        .emr_cfg  (emr_cfg),
        .emr2_cfg (emr2_cfg),
        .emr3_cfg (emr3_cfg),
        .word     (word),
        .addr     (addr)
    );

    assign cke                       = (phase_q != PH_CKE_LOW);
    assign {cs_n, ras_n, cas_n, we_n} = word.cmd;
    assign ba                        = BA_W'(word.sel);
    assign init_done                 = (phase_q == PH_DONE);
    assign read_ok                   = init_done && dll_locked;

endmodule

// File: rtl/ddr2_boot_seq_chk.sv
module ddr2_boot_seq_chk #(
    parameter int ADDR_W = 14,
    parameter int BA_W   = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              cke,
    input logic [3:0]        cmd,
    input logic [BA_W-1:0]   ba,
    input logic [ADDR_W-1:0] addr,
    input logic              init_done,
    input logic              read_ok
);

    // R1
    cke_low_nop_chk: assert property (@(posedge clk) disable iff (rst)
        !cke |-> (cmd == 4'b0111));

    // R2
    cke_hold_chk: assert property (@(posedge clk) disable iff (rst)
        cke |=> cke);

    // R3
    pre_all_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == 4'b0010) |-> addr[10]);

    // R10
    ref_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == 4'b0001) |-> (ba == '0 && addr == '0));

    // R11
    done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done);

    // R11
    done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        init_done |-> (cmd == 4'b0111));

    // R12
    read_gate_chk: assert property (@(posedge clk) disable iff (rst)
        read_ok |-> init_done);

    // R13
    restart_chk: assert property (@(posedge clk)
        rst |=> (!cke && !init_done && !read_ok));

endmodule

bind ddr2_boot_seq ddr2_boot_seq_chk #(
    .ADDR_W (ADDR_W),
    .BA_W   (BA_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cke       (cke),
    .cmd       ({cs_n, ras_n, cas_n, we_n}),
    .ba        (ba),
    .addr      (addr),
    .init_done (init_done),
    .read_ok   (read_ok)
);

// File: tb/ddr2_boot_seq_bench.sv
module ddr2_boot_seq_bench;

    localparam int AW    = 14;
    localparam int BAW   = 2;
    localparam int TL    = 50;
    localparam int TS    = 20;
    localparam int TRPA  = 4;
    localparam int TMRD  = 2;
    localparam int TRFC  = 9;
    localparam int TDLL  = 60;
    localparam int NREF  = 2;
    localparam int NSTEP = 9 + NREF;
    localparam int RST_IDX = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] mr_cfg = '0, emr_cfg = '0, emr2_cfg = '0, emr3_cfg = '0;
    logic          cke, cs_n, ras_n, cas_n, we_n, init_done, read_ok;
    logic [BAW-1:0] ba;
    logic [AW-1:0] addr;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    int            e_cyc [NSTEP];
    logic [3:0]    e_cmd [NSTEP];
    logic [1:0]    e_ba  [NSTEP];
    logic [AW-1:0] e_adr [NSTEP];
    int            done_k, rd_k;

    always #10 clk = ~clk;

    ddr2_boot_seq #(
        .ADDR_W (AW), .BA_W (BAW), .T_CKE_LOW (TL), .T_SETTLE (TS),
        .T_RPA (TRPA), .T_MRD (TMRD), .T_RFC (TRFC), .T_DLL (TDLL),
        .NUM_REF (NREF)
    ) u_ddr2_boot_seq (
        .clk (clk), .rst (rst), .mr_cfg (mr_cfg), .emr_cfg (emr_cfg),
        .emr2_cfg (emr2_cfg), .emr3_cfg (emr3_cfg), .cke (cke),
        .cs_n (cs_n), .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n),
        .ba (ba), .addr (addr), .init_done (init_done), .read_ok (read_ok)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [3:0] cur_cmd();
        return {cs_n, ras_n, cas_n, we_n};
    endfunction

    // Expected command list, built from the requirements
    task automatic build_expect();
        int n = 0;
        int c = TL + TS;
        int g;
        for (int i = 0; i < NSTEP; i++) begin
            e_ba[i]  = 2'b00;
            e_adr[i] = '0;
            e_cmd[i] = 4'b0000;
            g        = TMRD;
            if (i == 0 || i == 5) begin
                e_cmd[i] = 4'b0010; e_adr[i][10] = 1'b1; g = TRPA;
            end else if (i == 1) begin
                e_ba[i] = 2'b10; e_adr[i] = emr2_cfg;
            end else if (i == 2) begin
                e_ba[i] = 2'b11; e_adr[i] = emr3_cfg;
            end else if (i == 3) begin
                e_ba[i] = 2'b01; e_adr[i] = emr_cfg & ~AW'(14'h0381);
            end else if (i == 4) begin
                e_adr[i] = mr_cfg | AW'(14'h0100);
            end else if (i < 6 + NREF) begin
                e_cmd[i] = 4'b0001; g = TRFC;
            end else if (i == 6 + NREF) begin
                e_adr[i] = mr_cfg & ~AW'(14'h0100);
            end else if (i == 7 + NREF) begin
                e_ba[i] = 2'b01;
                e_adr[i] = (emr_cfg & ~AW'(14'h0001)) | AW'(14'h0380);
            end else begin
                e_ba[i] = 2'b01; e_adr[i] = emr_cfg & ~AW'(14'h0381);
            end
            e_cyc[i] = c;
            c = c + g;
            n++;
        end
        done_k = c;
        rd_k   = (done_k > e_cyc[RST_IDX] + TDLL) ? done_k : e_cyc[RST_IDX] + TDLL;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // Runs edges 1..stop_k after reset release, checking every sample
    task automatic run_check(input string tag, input int stop_k);
        int ptr = 0;
        int bad_cke = 0, bad_nop = 0, bad_done = 0, bad_rd = 0;
        int first_cke = -1;
        for (int k = 1; k <= stop_k; k++) begin
            @(negedge clk);
            if (cke && first_cke < 0) first_cke = k;
            if (cke != (k >= TL)) bad_cke++;
            if (ptr < NSTEP && k == e_cyc[ptr]) begin
                check({cur_cmd(), ba, addr} == {e_cmd[ptr], e_ba[ptr], e_adr[ptr]},
                      (ptr == 0) ? "R3" : (ptr == RST_IDX || ptr == 6 + NREF) ? "R8" :
                      (ptr == 1 || ptr == 2) ? "R6" : (ptr == 3) ? "R7" :
                      (ptr > 6 + NREF) ? "R9" : (e_cmd[ptr] == 4'b0001) ? "R10" : "R4",
                      $sformatf("%s step %0d at edge %0d", tag, ptr, k),
                      {cur_cmd(), ba, addr}, {e_cmd[ptr], e_ba[ptr], e_adr[ptr]});
                ptr++;
            end else if (cur_cmd() != 4'b0111 || ba != '0 || addr != '0) begin
                bad_nop++;
            end
            if (init_done != (k >= done_k)) bad_done++;
            if (read_ok != (k >= rd_k)) bad_rd++;
        end
        check(bad_cke == 0, "R1", {tag, " cke low window / R2 hold"}, bad_cke, 0);
        check(first_cke == TL, "R1", {tag, " cke rise edge"}, first_cke, TL);
        check(bad_nop == 0, "R5", {tag, " NOP between commands"}, bad_nop, 0);
        check(bad_done == 0, "R11", {tag, " init_done timing"}, bad_done, 0);
        check(bad_rd == 0, "R12", {tag, " read_ok timing"}, bad_rd, 0);
        if (stop_k >= done_k)
            check(ptr == NSTEP, "R4", {tag, " command count"}, ptr, NSTEP);
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(cke == 1'b0, "R1", "reset cke", cke, 0);
        check(cur_cmd() == 4'b0111, "R1", "reset cmd", cur_cmd(), 4'b0111);
        check(ba == '0 && addr == '0, "R1", "reset bus", {ba, addr}, 0);
        check(!init_done && !read_ok, "R1", "reset flags", {init_done, read_ok}, 0);
    endtask

    task automatic t_seq_plain();
        mr_cfg = AW'(14'h0432); emr_cfg = AW'(14'h0044);
        emr2_cfg = '0; emr3_cfg = '0;
        build_expect();
        do_reset();
        run_check("plain", done_k + 40);
    endtask

    task automatic t_seq_owned_bits();
        // Inputs with the owned bits set the wrong way: R7 R8 R9 force them
        mr_cfg = AW'(14'h2A53); emr_cfg = AW'(14'h3FFF);
        emr2_cfg = AW'(14'h0155); emr3_cfg = AW'(14'h2AAA);
        build_expect();
        do_reset();
        run_check("owned", done_k + 40);
    endtask

    task automatic t_restart();
        mr_cfg = AW'(14'h0163); emr_cfg = AW'(14'h0406);
        emr2_cfg = AW'(14'h0080); emr3_cfg = AW'(14'h0001);
        build_expect();
        do_reset();
        run_check("pre-restart", e_cyc[6] + 1);
        rst = 1'b1;
        @(negedge clk);
        check(cke == 1'b0 && cur_cmd() == 4'b0111, "R13", "restart cke/cmd",
              {cke, cur_cmd()}, 5'b00111);
        check(!init_done, "R13", "restart init_done", init_done, 0);
        rst = 1'b0;
        run_check("restart", done_k + 20);
    endtask

    initial begin
        t_reset_state();
        t_seq_plain();
        t_seq_owned_bits();
        t_restart();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule